// File: doc/BRIEF.md
# Four-Phase Interlocked Bus Handshake Pair

This block holds two bus agents that talk over an unclocked-style request/acknowledge protocol, both placed inside one synchronous clock domain. An initiator agent takes a single-word command (address, direction, data word) from a local command port. It places the address, direction and data on shared bus lines and holds them there for a programmable decode interval so that a responder can compare the address. Only then does it raise request.

The responder agent brings request into its own clock through a two-flop synchronizer and answers with acknowledge when the address equals its fixed base. On a write it captures the data word. The exchange is fully interlocked. Request goes up, then acknowledge goes up, then request goes down, then acknowledge goes down. Each agent moves only after it has seen the other's last move through its synchronizer.

If acknowledge never arrives within a programmable number of cycles, the initiator withdraws request and pulses a timeout flag. Before it accepts more work, it waits until any late acknowledge has been released.

Top module: `ilk_bus_pair`

## Requirements
- R1: While reset is asserted and after its release, bus_req, bus_ack, done, timeout and slv_wr_valid are 0 and cmd_ready is 1.
- R2: When cmd_valid is 1 while cmd_ready is 1, the command is accepted on that clock edge, and bus_addr, bus_data and bus_dir show it after that edge. bus_req rises exactly decode_cycles+1 clock cycles after the accepting edge.
- R3: The initiator lowers bus_req only after bus_ack has been seen high, except on a timeout. The responder lowers bus_ack only while bus_req is low.
- R4: bus_addr, bus_data and bus_dir stay unchanged from the accepting edge until cmd_ready returns to 1.
- R5: On a completed exchange, done is a one-cycle pulse, issued in the cycle in which cmd_ready returns to 1 after bus_ack has gone low.
- R6: The responder pulses slv_wr_valid for one cycle, with slv_wr_data equal to bus_data, once per request whose bus_addr equals SLAVE_BASE (0x3C by default) and whose bus_dir is 1 (write). With bus_dir 0 (read), it acknowledges but captures nothing.
- R7: For an address other than SLAVE_BASE, bus_ack stays 0. bus_req stays high for exactly timeout_cycles+1 cycles, then falls together with a one-cycle timeout pulse, and done is not asserted.
- R8: After a timeout, cmd_ready returns to 1 only once any acknowledge that the withdrawn request caused has been released. A following command then completes normally.
- R9: cmd_valid while cmd_ready is 0 is ignored: the bus lines keep the accepted command and no extra write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | Direction, 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_data | input | DW | Command data word |
| decode_cycles | input | CW | Decode interval before request |
| timeout_cycles | input | CW | Acknowledge wait limit |
| cmd_ready | output | 1 | Initiator idle, command accepted |
| done | output | 1 | Exchange complete pulse |
| timeout | output | 1 | Acknowledge timeout pulse |
| bus_req | output | 1 | Bus request line |
| bus_ack | output | 1 | Bus acknowledge line |
| bus_dir | output | 1 | Bus direction line |
| bus_addr | output | AW | Bus address lines |
| bus_data | output | DW | Bus data lines |
| slv_wr_valid | output | 1 | Responder captured a write |
| slv_wr_data | output | DW | Captured data word |

## Verification
The bench measures the gap from command acceptance to request for a zero decode interval and for longer ones. An off-by-one counter shows up there as a request one cycle early or late. It offers new commands while the initiator is busy, which a design with a loose ready gate would pick up, corrupting the bus lines or adding a write. It sends an address with no responder and counts the cycles request stays high, which catches a timeout limit that is off by one. It also sets a limit shorter than the round trip on a matching address, so the acknowledge arrives after request has been withdrawn. An initiator that returned to idle at once would then raise a new request over a still-high acknowledge and break the next exchange.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_SETUP,
    M_REQ,
    M_RELEASE,
    M_DRAIN
  } mst_state_t;
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ilk_master.sv
module ilk_master
  import ilk_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int CW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [CW-1:0] decode_cycles,
  input  logic [CW-1:0] timeout_cycles,
  input  logic          ack_s,
  output logic          cmd_ready,
  output logic          done,
  output logic          timeout,
  output logic          bus_req,
  output logic          bus_dir,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);
  localparam logic [CW-1:0] GUARD = CW'(2 * STAGES);

  mst_state_t    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          req_n, done_n, to_n, load;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    req_n   = bus_req;
    done_n  = 1'b0;
    to_n    = 1'b0;
    load    = 1'b0;
    case (state)
      M_IDLE: begin
        if (cmd_valid) begin
          load    = 1'b1;
          cnt_n   = '0;
          state_n = M_SETUP;
        end
      end
      M_SETUP: begin
        if (cnt == decode_cycles) begin
          req_n   = 1'b1;
          cnt_n   = '0;
          state_n = M_REQ;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      M_REQ: begin
        if (ack_s) begin
          req_n   = 1'b0;
          state_n = M_RELEASE;
        end else if (cnt == timeout_cycles) begin
          req_n   = 1'b0;
          to_n    = 1'b1;
          cnt_n   = '0;
          state_n = M_DRAIN;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      M_RELEASE: begin
        if (!ack_s) begin
          done_n  = 1'b1;
          state_n = M_IDLE;
        end
      end
      M_DRAIN: begin
        if (cnt < GUARD)  cnt_n   = cnt + 1'b1;
        else if (!ack_s)  state_n = M_IDLE;
      end
      default: state_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= M_IDLE;
      cnt     <= '0;
      bus_req <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      bus_req <= req_n;
      done    <= done_n;
      timeout <= to_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_data <= '0;
      bus_dir  <= 1'b0;
    end else if (load) begin
      bus_addr <= cmd_addr;
      bus_data <= cmd_data;
      bus_dir  <= cmd_write;
    end
  end

  assign cmd_ready = (state == M_IDLE);
endmodule

// File: rtl/ilk_slave.sv
module ilk_slave #(
  parameter int          AW   = 8,
  parameter int          DW   = 16,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic          bus_dir,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          bus_ack,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data
);
  logic req_d, hit, rise, ack_n, wr_n;

  assign hit  = (bus_addr == BASE);
  assign rise = req_s && !req_d;

  always_comb begin
    if (!req_s)          ack_n = 1'b0;
    else if (rise && hit) ack_n = 1'b1;
    else                 ack_n = bus_ack;
    wr_n = rise && hit && bus_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d    <= 1'b0;
      bus_ack  <= 1'b0;
      wr_valid <= 1'b0;
    end else begin
      req_d    <= req_s;
      bus_ack  <= ack_n;
      wr_valid <= wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wr_data <= '0;
    else if (wr_n) wr_data <= bus_data;
  end
endmodule

// File: rtl/ilk_bus_pair.sv
module ilk_bus_pair #(
  parameter int            AW          = 8,
  parameter int            DW          = 16,
  parameter int            CW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] SLAVE_BASE  = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [CW-1:0] decode_cycles,
  input  logic [CW-1:0] timeout_cycles,
  output logic          cmd_ready,
  output logic          done,
  output logic          timeout,
  output logic          bus_req,
  output logic          bus_ack,
  output logic          bus_dir,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          slv_wr_valid,
  output logic [DW-1:0] slv_wr_data
);
  logic rst_n_i, req_s, ack_s;

  ilk_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_i)
  );

  ilk_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n_i), .d(bus_req), .q(req_s)
  );

  ilk_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n_i), .d(bus_ack), .q(ack_s)
  );

  ilk_master #(.AW(AW), .DW(DW), .CW(CW), .STAGES(SYNC_STAGES)) u_master (
    .clk(clk), .rst_n(rst_n_i),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .decode_cycles(decode_cycles), .timeout_cycles(timeout_cycles),
    .ack_s(ack_s), .cmd_ready(cmd_ready), .done(done), .timeout(timeout),
    .bus_req(bus_req), .bus_dir(bus_dir),
    .bus_addr(bus_addr), .bus_data(bus_data)
  );

  ilk_slave #(.AW(AW), .DW(DW), .BASE(SLAVE_BASE)) u_slave (
    .clk(clk), .rst_n(rst_n_i), .req_s(req_s),
    .bus_dir(bus_dir), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ack(bus_ack), .wr_valid(slv_wr_valid), .wr_data(slv_wr_data)
  );
endmodule

// File: rtl/ilk_bus_pair_chk.sv
module ilk_bus_pair_chk #(
  parameter int            AW         = 8,
  parameter int            DW         = 16,
  parameter logic [AW-1:0] SLAVE_BASE = 8'h3C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          done,
  input logic          timeout,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_dir,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input logic          slv_wr_valid
);
  // R2: lines were settled before request rises
  a_r2_setup_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($stable(bus_addr) && $stable(bus_data) && $stable(bus_dir)));

  // R4: lines held while either handshake line is high
  a_r4_hold_during_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || bus_ack) |-> ($stable(bus_addr) && $stable(bus_data) && $stable(bus_dir)));

  // R3: acknowledge released only with request low
  a_r3_ack_falls_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !bus_req);

  // R8: no new request over a lingering acknowledge
  a_r8_req_after_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_ack);

  // R5/R7: completion and timeout never together
  a_r5_done_timeout_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  // R2: idle initiator drives no request
  a_r2_ready_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_req);

  // R6: captures only for a matching write
  a_r6_write_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    slv_wr_valid |-> (bus_addr == SLAVE_BASE && bus_dir));
endmodule

bind ilk_bus_pair ilk_bus_pair_chk #(.AW(AW), .DW(DW), .SLAVE_BASE(SLAVE_BASE)) u_chk (.*);

// File: tb/ilk_bus_pair_bench.sv
module ilk_bus_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_write;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic [7:0]  decode_cycles, timeout_cycles;
  logic        cmd_ready, done, timeout, bus_req, bus_ack, bus_dir;
  logic [7:0]  bus_addr;
  logic [15:0] bus_data;
  logic        slv_wr_valid;
  logic [15:0] slv_wr_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] exp_wr_q[$];
  bit          exp_res_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ilk_bus_pair u_ilk_bus_pair (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for writes and completions
  always @(negedge clk) begin
    if (rst_n) begin
      if (slv_wr_valid) begin
        if (exp_wr_q.size() == 0) check(0, "R6/R9 unexpected write", slv_wr_data, 0);
        else begin
          logic [15:0] e;
          e = exp_wr_q.pop_front();
          check(slv_wr_data == e, "R6 write data", slv_wr_data, e);
        end
      end
      if (done || timeout) begin
        if (exp_res_q.size() == 0) check(0, "R5/R7 unexpected result", {done, timeout}, 0);
        else begin
          bit e;
          e = exp_res_q.pop_front();
          check(timeout == e && done == !e, "R5/R7 result kind", {done, timeout}, {!e, e});
        end
      end
    end
  end

  task automatic send(input logic [7:0] a, input logic [15:0] d, input bit dir,
                      input int dec, input int tmo, input bit junk,
                      input bit exp_to, input bit exp_wr);
    int n, hi;
    bit stable_ok, r3_ok, prev_req, prev_ack;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_addr = a; cmd_data = d; cmd_write = dir;
    decode_cycles = 8'(dec); timeout_cycles = 8'(tmo);
    cmd_valid = 1'b1;
    if (exp_wr) exp_wr_q.push_back(d);
    exp_res_q.push_back(exp_to);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_addr == a && bus_data == d && bus_dir == dir, "R2 lines take command", bus_data, d);
    n = 0;
    while (!bus_req) begin @(negedge clk); n++; end
    check(n == dec + 1, "R2 decode delay", n, dec + 1);
    hi = 1; stable_ok = 1; r3_ok = 1; prev_req = 1; prev_ack = bus_ack;
    while (!cmd_ready) begin
      cmd_valid = junk && bus_req;            // R9 offered while busy
      if (junk) begin cmd_addr = BASE; cmd_data = ~d; cmd_write = 1'b1; end
      @(negedge clk);
      if (bus_req) hi++;
      if ((bus_req || bus_ack) && (bus_addr != a || bus_data != d || bus_dir != dir)) stable_ok = 0;
      if (prev_req && !bus_req && !exp_to && !bus_ack) r3_ok = 0;
      if (prev_ack && !bus_ack && bus_req) r3_ok = 0;
      prev_req = bus_req; prev_ack = bus_ack;
    end
    cmd_valid = 1'b0;
    check(stable_ok, "R4 lines held (R9 when busy)", 0, 1);
    check(bus_addr == a && bus_data == d, "R4/R9 lines at end", bus_data, d);
    if (!exp_to) begin
      check(r3_ok, "R3 interlock order", 0, 1);
      check(done == 1'b1, "R5 done with ready", done, 1);
    end else begin
      check(hi == tmo + 1, "R7 request width on timeout", hi, tmo + 1);
      check(done == 1'b0 && bus_ack == 1'b0, "R8 ack released before ready", {done, bus_ack}, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_data = 0;
    decode_cycles = 0; timeout_cycles = 0;
    repeat (3) @(negedge clk);
    check(!bus_req && !bus_ack && !done && !timeout && !slv_wr_valid && cmd_ready,
          "R1 reset state", {bus_req, bus_ack, done, timeout, slv_wr_valid, cmd_ready}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!bus_req && !bus_ack && cmd_ready, "R1 after release", {bus_req, bus_ack, cmd_ready}, 1);

    send(BASE, 16'hA5A5, 1, 0, 20, 0, 0, 1);   // R2 zero decode interval
    send(BASE, 16'h1234, 1, 3, 20, 0, 0, 1);   // R6 write
    send(BASE, 16'hBEEF, 1, 7, 20, 1, 0, 1);   // R9 busy offers
    send(BASE, 16'h5555, 0, 2, 20, 0, 0, 0);   // R6 read: ack, no capture
    send(8'h11, 16'hDEAD, 1, 1, 10, 0, 1, 0);  // R7 no responder
    send(BASE, 16'hCAFE, 1, 0, 2, 0, 1, 1);    // R8 late acknowledge
    send(BASE, 16'h0F0F, 1, 4, 20, 0, 0, 1);   // R8 follow-up completes

    repeat (10) @(negedge clk);
    check(exp_wr_q.size() == 0, "R6 all writes seen", exp_wr_q.size(), 0);
    check(exp_res_q.size() == 0, "R5 all results seen", exp_res_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule